// File: doc/BRIEF.md
# Strip Cluster Width Discriminator

This block sits on the trigger path of a two-layer binary strip readout chip. It takes one bunch crossing (40 MHz) of comparator hits, 127 channels for the lower sensor layer and 127 for the upper. Noisy channels are removed first with a per-channel mask. The block then finds contiguous runs of hit strips in each layer. A run wider than a programmable limit of 1, 2 or 3 strips is thrown away. Each run that survives is marked at its centre, on a half-strip grid. The result is a centre map per layer, plus the lowest lower-layer centre as an 8-bit code. The correlation logic downstream uses these to build its stubs.

Clusters can cross the chip boundary. To handle this, adjacent chips exchange masked edge hits through neighbour ports. A cluster belongs to the chip that holds its lowest strip. That chip also sees the strips beyond its top edge, so it can measure the full width of the cluster. Both centre maps and the 8-bit position are registered, one clock after the hits are sampled. The neighbour outputs are combinational.

Top module: `strip_cwd`

## Requirements
- R1: While rst_ni is low, cent_lo_o, cent_up_o, pos_o and pos_vld_o are all zero.
- R2: Outputs reflect the inputs sampled at the previous rising clock edge. The outputs hold their values between edges.
- R3: A channel whose mask bit is 1 counts as not hit. A masked channel inside a run of hits splits that run into two clusters. Channel ch of layer l is bit l*127+ch of hits_i and of mask_i; the lower layer is l=0.
- R4: A cluster of width w is reported only when 1 <= w <= cfg_width_i. When cfg_width_i is 0, no cluster is reported.
- R5: A reported cluster whose lowest strip is i sets bit 2i of its layer's centre map if it is 1 strip wide, bit 2i+1 if 2 strips wide, and bit 2i+2 if 3 strips wide.
- R6: pos_vld_o is 1 exactly when cent_lo_o has any bit set. pos_o then equals the index of the lowest set bit. When pos_vld_o is 0, pos_o is 0.
- R7: nbr_lo_i bit l gives the masked hit of the strip just below channel 0 of layer l. A cluster that continues into that strip is not reported by this chip.
- R8: nbr_hi_i bit l*3+k gives the masked hit of strip 127+k of layer l. These strips count toward the width of a cluster that starts on this chip, so centre codes reach 254.
- R9: nbr_lo_o bit l*3+k is the masked hit of channel k of layer l. nbr_hi_o bit l is the masked hit of channel 126 of layer l. Both follow the inputs combinationally.
- R10: The two layers are processed independently. Hits in one layer never change the other layer's centre map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hits_i | input | 254 | Comparator hits, bit l*127+ch |
| mask_i | input | 254 | Channel masks, 1 removes the hit |
| cfg_width_i | input | 2 | Maximum accepted cluster width, 0 disables |
| nbr_lo_i | input | 2 | Masked hit of strip below channel 0, per layer |
| nbr_hi_i | input | 6 | Masked hits of strips 127..129, per layer |
| nbr_lo_o | output | 6 | Masked hits of channels 0..2, per layer |
| nbr_hi_o | output | 2 | Masked hit of channel 126, per layer |
| cent_lo_o | output | 255 | Lower-layer centre map, bit = half-strip code |
| cent_up_o | output | 255 | Upper-layer centre map, bit = half-strip code |
| pos_o | output | 8 | Lowest lower-layer centre code |
| pos_vld_o | output | 1 | Lower layer has at least one cluster |

## Verification
Start detection or run-length logic with a bad state shows up at the ports on the edge after the stimulus. It appears as a centre bit at the wrong code, a missing bit, or two bits closer than four codes apart. A stale or mis-ordered position register shows up the same way, as a pos_o that does not equal the lowest set bit of cent_lo_o. In-RTL properties compare these registered values every cycle. Edge and ownership faults only show for hits on channels 0..2 and 124..126. For that reason the bench drives those channels together with the neighbour inputs.

// File: rtl/strip_cwd_pkg.sv
package strip_cwd_pkg;
  localparam int unsigned N_CH    = 127;
  localparam int unsigned N_LAYER = 2;
  localparam int unsigned MAX_W   = 3;
  localparam int unsigned MAP_W   = 2 * (N_CH - 1) + MAX_W;
  localparam int unsigned CODE_W  = $clog2(MAP_W);
  localparam int unsigned CFG_W   = $clog2(MAX_W + 1);
endpackage

// File: rtl/cwd_mask.sv
module cwd_mask #(
  parameter int unsigned N_CH    = 127,
  parameter int unsigned N_LAYER = 2,
  parameter int unsigned MAX_W   = 3,
  localparam int unsigned TOT    = N_CH * N_LAYER
) (
  input  logic [TOT-1:0]           hits_i,
  input  logic [TOT-1:0]           mask_i,
  output logic [TOT-1:0]           masked_o,
  output logic [N_LAYER*MAX_W-1:0] nbr_lo_o,
  output logic [N_LAYER-1:0]       nbr_hi_o
);
  assign masked_o = hits_i & ~mask_i;

  for (genvar l = 0; l < N_LAYER; l++) begin : g_edge
    assign nbr_lo_o[l*MAX_W +: MAX_W] = masked_o[l*N_CH +: MAX_W];
    assign nbr_hi_o[l]                = masked_o[l*N_CH + N_CH - 1];
  end
endmodule

// File: rtl/cwd_cluster.sv
module cwd_cluster #(
  parameter int unsigned N_CH  = 127,
  parameter int unsigned MAX_W = 3,
  parameter int unsigned CFG_W = 2,
  localparam int unsigned MAP_W = 2 * (N_CH - 1) + MAX_W,
  localparam int unsigned EXT_W = N_CH + 1 + MAX_W
) (
  input  logic [N_CH-1:0]  hits_i,
  input  logic             nbr_lo_i,
  input  logic [MAX_W-1:0] nbr_hi_i,
  input  logic [CFG_W-1:0] cfg_width_i,
  output logic [MAP_W-1:0] cent_o
);
  // ext[0] = strip below ch0, ext[ch+1] = ch, top MAX_W = strips beyond edge
  logic [EXT_W-1:0] ext;
  assign ext = {nbr_hi_i, hits_i, nbr_lo_i};

  logic [N_CH-1:0][MAX_W-1:0] acc;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic st;
    assign st = ext[ch+1] & ~ext[ch];
    for (genvar w = 1; w <= MAX_W; w++) begin : g_w
      assign acc[ch][w-1] = st & (&ext[ch+1 +: w]) & ~ext[ch+1+w]
                          & (cfg_width_i >= CFG_W'(w));
    end
  end

  always_comb begin
    cent_o = '0;
    for (int ch = 0; ch < N_CH; ch++) begin
      for (int w = 0; w < MAX_W; w++) begin
        if (acc[ch][w]) cent_o[2*ch + w] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cwd_first.sv
module cwd_first #(
  parameter int unsigned MAP_W  = 255,
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MAP_W-1:0]  map_i,
  output logic [CODE_W-1:0] pos_o,
  output logic              vld_o
);
  logic [CODE_W-1:0] pos_d;

  always_comb begin
    pos_d = '0;
    for (int j = MAP_W - 1; j >= 0; j--) begin
      if (map_i[j]) pos_d = CODE_W'(j);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o <= '0;
      vld_o <= 1'b0;
    end else begin
      pos_o <= pos_d;
      vld_o <= |map_i;
    end
  end

  // R6
  zero_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> pos_o == '0);
endmodule

// File: rtl/strip_cwd.sv
module strip_cwd
  import strip_cwd_pkg::*;
#(
  parameter int unsigned CH     = N_CH,
  parameter int unsigned LAYERS = N_LAYER,
  parameter int unsigned WMAX   = MAX_W,
  localparam int unsigned TOT   = CH * LAYERS,
  localparam int unsigned MW    = 2 * (CH - 1) + WMAX,
  localparam int unsigned CW    = $clog2(MW),
  localparam int unsigned FW    = $clog2(WMAX + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [TOT-1:0]          hits_i,
  input  logic [TOT-1:0]          mask_i,
  input  logic [FW-1:0]           cfg_width_i,
  input  logic [LAYERS-1:0]       nbr_lo_i,
  input  logic [LAYERS*WMAX-1:0]  nbr_hi_i,
  output logic [LAYERS*WMAX-1:0]  nbr_lo_o,
  output logic [LAYERS-1:0]       nbr_hi_o,
  output logic [MW-1:0]           cent_lo_o,
  output logic [MW-1:0]           cent_up_o,
  output logic [CW-1:0]           pos_o,
  output logic                    pos_vld_o
);
  logic [TOT-1:0]           masked;
  logic [LAYERS-1:0][MW-1:0] cent_d;

  cwd_mask #(.N_CH(CH), .N_LAYER(LAYERS), .MAX_W(WMAX)) i_mask (
    .hits_i   (hits_i),
    .mask_i   (mask_i),
    .masked_o (masked),
    .nbr_lo_o (nbr_lo_o),
    .nbr_hi_o (nbr_hi_o)
  );

  for (genvar l = 0; l < LAYERS; l++) begin : g_layer
    cwd_cluster #(.N_CH(CH), .MAX_W(WMAX), .CFG_W(FW)) i_cluster (
      .hits_i      (masked[l*CH +: CH]),
      .nbr_lo_i    (nbr_lo_i[l]),
      .nbr_hi_i    (nbr_hi_i[l*WMAX +: WMAX]),
      .cfg_width_i (cfg_width_i),
      .cent_o      (cent_d[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cent_lo_o <= '0;
      cent_up_o <= '0;
    end else begin
      cent_lo_o <= cent_d[0];
      cent_up_o <= cent_d[LAYERS-1];
    end
  end

  cwd_first #(.MAP_W(MW), .CODE_W(CW)) i_first (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .map_i  (cent_d[0]),
    .pos_o  (pos_o),
    .vld_o  (pos_vld_o)
  );

  // R4
  cfg_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_width_i == '0 |=> (cent_lo_o == '0 && cent_up_o == '0));

  // R6
  first_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_vld_o |-> cent_lo_o[pos_o]);

  // R6
  lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_vld_o |-> (cent_lo_o & ((MW'(1) << pos_o) - MW'(1))) == '0);

  // R6
  vld_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_vld_o == (cent_lo_o != '0));

  // R5: distinct clusters sit at least four half-strip codes apart
  spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cent_lo_o & (cent_lo_o >> 1)) | (cent_lo_o & (cent_lo_o >> 2)) |
     (cent_lo_o & (cent_lo_o >> 3)) | (cent_up_o & (cent_up_o >> 1)) |
     (cent_up_o & (cent_up_o >> 2)) | (cent_up_o & (cent_up_o >> 3))) == '0);
endmodule

// File: tb/test_strip_cwd.sv
module test_strip_cwd;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [253:0] hits_i = '0;
  logic [253:0] mask_i = '0;
  logic [1:0]   cfg_width_i = 2'd3;
  logic [1:0]   nbr_lo_i = '0;
  logic [5:0]   nbr_hi_i = '0;
  logic [5:0]   nbr_lo_o;
  logic [1:0]   nbr_hi_o;
  logic [254:0] cent_lo_o, cent_up_o;
  logic [7:0]   pos_o;
  logic         pos_vld_o;

  int tests = 0;
  int failed = 0;

  strip_cwd i_strip_cwd (.*);

  always #10 clk_i = ~clk_i;

  typedef struct packed {
    logic [1:0] cfg;
    logic [6:0] st;
    logic [4:0] pat;
    logic [4:0] msk;
    logic [7:0] c0, c1, c2;
  } vec_t;

  // lower layer only; codes ascending, 255 = none
  localparam vec_t VECS [12] = '{
    '{2'd3, 7'd10, 5'b00001, 5'b00000, 8'd20,  8'd255, 8'd255},
    '{2'd3, 7'd10, 5'b00011, 5'b00000, 8'd21,  8'd255, 8'd255},
    '{2'd3, 7'd10, 5'b00111, 5'b00000, 8'd22,  8'd255, 8'd255},
    '{2'd3, 7'd10, 5'b01111, 5'b00000, 8'd255, 8'd255, 8'd255},
    '{2'd2, 7'd10, 5'b00111, 5'b00000, 8'd255, 8'd255, 8'd255},
    '{2'd2, 7'd40, 5'b00011, 5'b00000, 8'd81,  8'd255, 8'd255},
    '{2'd1, 7'd40, 5'b00011, 5'b00000, 8'd255, 8'd255, 8'd255},
    '{2'd1, 7'd0,  5'b00001, 5'b00000, 8'd0,   8'd255, 8'd255},
    '{2'd0, 7'd5,  5'b00001, 5'b00000, 8'd255, 8'd255, 8'd255},
    '{2'd3, 7'd20, 5'b11111, 5'b00100, 8'd41,  8'd47,  8'd255},
    '{2'd3, 7'd20, 5'b01111, 5'b01000, 8'd42,  8'd255, 8'd255},
    '{2'd1, 7'd20, 5'b10101, 5'b00000, 8'd40,  8'd44,  8'd48}
  };

  function automatic logic [254:0] build_map(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    logic [254:0] m = '0;
    if (a != 8'd255) m[a] = 1'b1;
    if (b != 8'd255) m[b] = 1'b1;
    if (c != 8'd255) m[c] = 1'b1;
    return m;
  endfunction

  task automatic chk(string req, logic [254:0] act, logic [254:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_lo(string req, logic [254:0] exp_map);
    logic [7:0] ep = '0;
    for (int j = 254; j >= 0; j--) if (exp_map[j]) ep = 8'(j);
    chk({req, " map"}, cent_lo_o, exp_map);
    chk({req, " pos"}, 255'(pos_o), 255'(ep));
    chk({req, " vld"}, 255'(pos_vld_o), 255'(exp_map != '0));
  endtask

  task automatic clear_in();
    hits_i = '0; mask_i = '0; nbr_lo_i = '0; nbr_hi_i = '0; cfg_width_i = 2'd3;
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  initial begin
    // R1: reset holds outputs low despite active hits
    hits_i[10] = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 lo", cent_lo_o, '0);
    chk("R1 up", cent_up_o, '0);
    chk("R1 pos", 255'({pos_vld_o, pos_o}), '0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R3 R4 R5 R6: vector table
    foreach (VECS[i]) begin
      @(negedge clk_i);
      clear_in();
      cfg_width_i = VECS[i].cfg;
      hits_i[126:0] = 127'(VECS[i].pat) << VECS[i].st;
      mask_i[126:0] = 127'(VECS[i].msk) << VECS[i].st;
      step();
      chk_lo($sformatf("R3/R4/R5/R6 vec%0d", i),
             build_map(VECS[i].c0, VECS[i].c1, VECS[i].c2));
    end

    // R7: run touching nbr_lo belongs to the chip below
    @(negedge clk_i); clear_in(); hits_i[1:0] = 2'b11; nbr_lo_i[0] = 1'b1;
    step(); chk_lo("R7 owned below", '0);
    @(negedge clk_i); nbr_lo_i[0] = 1'b0;
    step(); chk_lo("R7 owned here", build_map(8'd1, 8'd255, 8'd255));

    // R8: runs extending past channel 126
    @(negedge clk_i); clear_in(); hits_i[126] = 1'b1; nbr_hi_i[2:0] = 3'b011;
    step(); chk_lo("R8 w3 at 126", build_map(8'd254, 8'd255, 8'd255));
    @(negedge clk_i); nbr_hi_i[2:0] = 3'b111;
    step(); chk_lo("R8 w4 rejected", '0);
    @(negedge clk_i); hits_i[125] = 1'b1; nbr_hi_i[2:0] = 3'b001;
    step(); chk_lo("R8 w3 at 125", build_map(8'd252, 8'd255, 8'd255));

    // R9: neighbour outputs, combinational
    @(negedge clk_i); clear_in();
    hits_i[2:0] = 3'b101; mask_i[2] = 1'b1; hits_i[126] = 1'b1; hits_i[127+126] = 1'b1;
    hits_i[127+1] = 1'b1;
    #1;
    chk("R9 nbr_lo_o", 255'(nbr_lo_o), 255'(6'b010_001));
    chk("R9 nbr_hi_o", 255'(nbr_hi_o), 255'(2'b11));
    mask_i[126] = 1'b1; #1;
    chk("R9 nbr_hi_o masked", 255'(nbr_hi_o), 255'(2'b10));

    // R10: upper layer is independent of lower
    @(negedge clk_i); clear_in(); hits_i[127+7] = 1'b1; hits_i[127+8] = 1'b1;
    step();
    chk("R10 up map", cent_up_o, build_map(8'd15, 8'd255, 8'd255));
    chk_lo("R10 lo untouched", '0);

    // R2: output holds until the next edge, then follows
    @(negedge clk_i); clear_in(); #1;
    chk("R2 hold", cent_up_o, build_map(8'd15, 8'd255, 8'd255));
    step();
    chk("R2 update", cent_up_o, '0);

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    #(20 * 100000);
    tests++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule